// File: doc/BRIEF.md
# Interrupt Mask and Latch Unit

This unit collects single-cycle event pulses from a serial engine and its FIFOs into a sticky latch register. A companion mask register selects which latched sources may raise the single interrupt line. Software reaches both registers through a small synchronous register port. Both registers accept a plain load. The mask also has an address that sets bits written as one and an address that clears bits written as one. This lets one mask bit change without a read-modify-write. The latch has an address that clears bits written as one, so a handler acknowledges only the sources it has serviced.

The source map is sparse. Ten sources sit at fixed bit positions. Bit 0, bit 3 and every bit from 12 upward are reserved: they hold zero, ignore writes and events, and read as zero. An event always sets its latch bit, masked or not, so unmasking a source later shows any event it missed. When an event and a clear hit the same latch bit in one cycle, the event wins.

Top module: `irq_mask_latch_unit`

## Requirements
- R1: After reset the mask and the latch are all zero, the interrupt output is low, and the read data is zero.
- R2: A write to address 0 loads the mask from the write data. Only the implemented bits are kept: 1, 2 and 4 through 11.
- R3: A write to address 1 ORs the implemented bits written as one into the mask. All other mask bits keep their value.
- R4: A write to address 2 clears the mask bits written as one. All other mask bits keep their value.
- R5: An event pulse on input bit n sets latch bit n at the next clock edge, whether or not mask bit n is set.
- R6: A write to address 4 clears the latch bits written as one. All other latch bits keep their value.
- R7: If an event and a clearing or loading write hit the same latch bit in one cycle, that latch bit ends up set.
- R8: The interrupt output is high exactly when some bit is set in both the latch and the mask.
- R9: The reserved bits (0, 3 and 12 upward) of the mask and the latch never become set, whether by writes or by events, and always read as zero.
- R10: A write to address 3 loads the latch from the implemented bits of the write data.
- R11: Writes to addresses 5 to 7 change nothing, and reads of those addresses return zero.
- R12: A read captures the selected register one clock edge after the read strobe. Addresses 0 to 2 return the mask, and addresses 3 and 4 return the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (3) | Register address for reads and writes |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, registered |
| evt_i | input | 12 | Event pulses, one bit per source position |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default values, a 32-bit data path and a 3-bit address. With 32-bit write data, the writes of all ones reach the reserved bits above bit 11. With a 3-bit address, the three unmapped addresses 5 to 7 can be exercised. The event input is 12 bits wide, so pulses on the reserved positions 0 and 3 can be driven and shown to have no effect. A second reset in the middle of the run checks that every register returns to zero.

// File: rtl/irq_ml_pkg.sv
package irq_ml_pkg;

  localparam int SRC_W = 12;

  localparam int A_MASK     = 0;
  localparam int A_MASK_SET = 1;
  localparam int A_MASK_CLR = 2;
  localparam int A_LAT      = 3;
  localparam int A_LAT_CLR  = 4;

  // positions that hold a real source
  function automatic logic [SRC_W-1:0] live_bits();
    logic [SRC_W-1:0] m;
    for (int i = 0; i < SRC_W; i++) begin
      m[i] = (i != 0) && (i != 3);
    end
    return m;
  endfunction

  function automatic logic [SRC_W-1:0] or_in(input logic [SRC_W-1:0] cur,
                                              input logic [SRC_W-1:0] w);
    return cur | w;
  endfunction

  function automatic logic [SRC_W-1:0] knock_out(input logic [SRC_W-1:0] cur,
                                                  input logic [SRC_W-1:0] w);
    return cur & ~w;
  endfunction

  function automatic logic any_pending(input logic [SRC_W-1:0] lat,
                                       input logic [SRC_W-1:0] msk);
    return |(lat & msk);
  endfunction

  typedef struct packed {
    logic mask_load;
    logic mask_set;
    logic mask_clr;
    logic lat_load;
    logic lat_clr;
  } wr_strobes_t;

endpackage

// File: rtl/irq_ml_decode.sv
module irq_ml_decode
  import irq_ml_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strobes_t       stb_o
);

  always_comb begin
    stb_o = '0;
    if (wr_en_i) begin
      stb_o.mask_load = (addr_i == ADDR_W'(A_MASK));
      stb_o.mask_set  = (addr_i == ADDR_W'(A_MASK_SET));
      stb_o.mask_clr  = (addr_i == ADDR_W'(A_MASK_CLR));
      stb_o.lat_load  = (addr_i == ADDR_W'(A_LAT));
      stb_o.lat_clr   = (addr_i == ADDR_W'(A_LAT_CLR));
    end
  end

endmodule

// File: rtl/irq_ml_mask.sv
module irq_ml_mask
  import irq_ml_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [SRC_W-1:0] wbits_i,
  output logic [SRC_W-1:0] mask_o
);

  localparam logic [SRC_W-1:0] LIVE = live_bits();

  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (load_i)     mask_d = wbits_i;
    else if (set_i) mask_d = or_in(mask_q, wbits_i);
    else if (clr_i) mask_d = knock_out(mask_q, wbits_i);
    mask_d = mask_d & LIVE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/irq_ml_latch.sv
module irq_ml_latch
  import irq_ml_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic [SRC_W-1:0] wbits_i,
  input  logic [SRC_W-1:0] evt_i,
  output logic [SRC_W-1:0] lat_o
);

  localparam logic [SRC_W-1:0] LIVE = live_bits();

  for (genvar g = 0; g < SRC_W; g++) begin : g_bit
    if (LIVE[g]) begin : g_live
      logic bit_q;
      logic bit_d;
      always_comb begin
        bit_d = bit_q;
        if (load_i)     bit_d = wbits_i[g];
        else if (clr_i) bit_d = bit_q & ~wbits_i[g];
        bit_d = bit_d | evt_i[g];   // event has priority
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= bit_d;
      end
      assign lat_o[g] = bit_q;
    end else begin : g_rsvd
      assign lat_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_ml_readback.sv
module irq_ml_readback
  import irq_ml_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SRC_W-1:0]  mask_i,
  input  logic [SRC_W-1:0]  lat_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [SRC_W-1:0]  sel_bits;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    sel_bits = '0;
    if (addr_i == ADDR_W'(A_MASK) || addr_i == ADDR_W'(A_MASK_SET) ||
        addr_i == ADDR_W'(A_MASK_CLR))
      sel_bits = mask_i;
    else if (addr_i == ADDR_W'(A_LAT) || addr_i == ADDR_W'(A_LAT_CLR))
      sel_bits = lat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= {{(DATA_W-SRC_W){1'b0}}, sel_bits};
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_mask_latch_unit.sv
module irq_mask_latch_unit
  import irq_ml_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [SRC_W-1:0]  evt_i,
  output logic              irq_o
);

  localparam logic [SRC_W-1:0] LIVE = live_bits();

  wr_strobes_t      stb;
  logic [SRC_W-1:0] wr_bits;
  logic [SRC_W-1:0] evt_live;
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] lat_q;

  assign wr_bits  = wdata_i[SRC_W-1:0] & LIVE;
  assign evt_live = evt_i & LIVE;

  irq_ml_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .stb_o   (stb)
  );

  irq_ml_mask u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (stb.mask_load),
    .set_i   (stb.mask_set),
    .clr_i   (stb.mask_clr),
    .wbits_i (wr_bits),
    .mask_o  (mask_q)
  );

  irq_ml_latch u_lat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (stb.lat_load),
    .clr_i   (stb.lat_clr),
    .wbits_i (wr_bits),
    .evt_i   (evt_live),
    .lat_o   (lat_q)
  );

  irq_ml_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .mask_i  (mask_q),
    .lat_i   (lat_q),
    .rdata_o (rdata_o)
  );

  assign irq_o = any_pending(lat_q, mask_q);

endmodule

// File: rtl/irq_mask_latch_unit_chk.sv
module irq_mask_latch_unit_chk
  import irq_ml_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input wr_strobes_t      stb,
  input logic [SRC_W-1:0] wr_bits,
  input logic [SRC_W-1:0] evt_live,
  input logic [SRC_W-1:0] mask_q,
  input logic [SRC_W-1:0] lat_q
);

  localparam logic [SRC_W-1:0] LIVE = live_bits();

  // R2 / R11: mask moves only on a mask write
  a_r2_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stb.mask_load || stb.mask_set || stb.mask_clr) |=> $stable(mask_q));

  a_r3_set_ors: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb.mask_set |=> ((mask_q & $past(wr_bits)) == $past(wr_bits)));

  a_r4_clr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb.mask_clr |=> ((mask_q & $past(wr_bits)) == '0));

  // R5 and R7: every live event is visible next cycle
  a_r5_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_live != '0) |=> ((lat_q & $past(evt_live)) == $past(evt_live)));

  a_r6_lat_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb.lat_clr |=> ((lat_q & $past(wr_bits & ~evt_live)) == '0));

  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_q | lat_q) & ~LIVE) == '0);

endmodule

bind irq_mask_latch_unit irq_mask_latch_unit_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stb      (stb),
  .wr_bits  (wr_bits),
  .evt_live (evt_live),
  .mask_q   (mask_q),
  .lat_q    (lat_q)
);

// File: tb/irq_mask_latch_unit_test.sv
module irq_mask_latch_unit_test;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int VW     = 73;
  localparam int NV     = 13;

  // {wr, addr, wdata, evt, exp_mask, exp_latch, exp_irq}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 3'd0, 32'hFFFF_FFFF, 12'h000, 12'hFF6, 12'h000, 1'b0}, // R2
    {1'b1, 3'd2, 32'h0000_0FF0, 12'h000, 12'h006, 12'h000, 1'b0}, // R4
    {1'b0, 3'd0, 32'h0000_0000, 12'h002, 12'h006, 12'h002, 1'b1}, // R5 R8
    {1'b0, 3'd0, 32'h0000_0000, 12'h010, 12'h006, 12'h012, 1'b1}, // R5 masked
    {1'b1, 3'd4, 32'h0000_0002, 12'h000, 12'h006, 12'h010, 1'b0}, // R6 R8
    {1'b1, 3'd1, 32'h0000_0010, 12'h000, 12'h016, 12'h010, 1'b1}, // R3
    {1'b1, 3'd4, 32'h0000_0010, 12'h010, 12'h016, 12'h010, 1'b1}, // R7
    {1'b0, 3'd0, 32'h0000_0000, 12'h009, 12'h016, 12'h010, 1'b1}, // R9
    {1'b1, 3'd3, 32'hFFFF_FFFF, 12'h000, 12'h016, 12'hFF6, 1'b1}, // R10
    {1'b1, 3'd4, 32'hFFFF_FFFF, 12'h000, 12'h016, 12'h000, 1'b0}, // R6
    {1'b1, 3'd5, 32'hFFFF_FFFF, 12'h000, 12'h016, 12'h000, 1'b0}, // R11
    {1'b1, 3'd2, 32'hFFFF_FFFF, 12'h800, 12'h000, 12'h800, 1'b0}, // R4 R5
    {1'b1, 3'd1, 32'h0000_0800, 12'h000, 12'h800, 12'h800, 1'b1}  // R3 R8
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [11:0]       evt = '0;
  logic              irq;

  int n_run = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_mask_latch_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .evt_i   (evt),
    .irq_o   (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    addr  = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic step(input logic w, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [11:0] e);
    @(negedge clk);
    wr_en = w;
    addr  = a;
    wdata = d;
    evt   = e;
    @(negedge clk);
    wr_en = 1'b0;
    wdata = '0;
    evt   = '0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rst_n = 1'b1;
    rd(3'd0, v); chk("R1 mask", v, 32'h0);
    rd(3'd3, v); chk("R1 latch", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][72], VEC[i][71:69], VEC[i][68:37], VEC[i][36:25]);
      chk($sformatf("R8 irq vec%0d", i), {31'b0, irq}, {31'b0, VEC[i][0]});
      rd(3'd0, v);
      chk($sformatf("R2-mask vec%0d R9", i), v, {20'b0, VEC[i][24:13]});
      rd(3'd3, v);
      chk($sformatf("R10-latch vec%0d R9", i), v, {20'b0, VEC[i][12:1]});
    end

    // R12 alias reads
    rd(3'd1, v); chk("R12 mask via set addr", v, 32'h800);
    rd(3'd4, v); chk("R12 latch via clr addr", v, 32'h800);
    // R11 unmapped read
    rd(3'd6, v); chk("R11 unmapped read", v, 32'h0);

    // R7 with load: event beats a latch load of zero
    step(1'b1, 3'd3, 32'h0, 12'h004);
    rd(3'd3, v); chk("R7 load vs event", v, 32'h004);

    // R1 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    rd(3'd0, v); chk("R1 mask after reset", v, 32'h0);
    rd(3'd3, v); chk("R1 latch after reset", v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule